// File: doc/BRIEF.md
# Bridge Polarity Steering With Dead Time

This block sits between a two-phase gate pulse generator and the two anti-parallel thyristor bridges of a four-quadrant converter. Two gate trains, spaced half a mains cycle apart, come in. They leave on one of two output pairs: the positive-bridge pair or the negative-bridge pair. A polarity command input chooses the pair. The outputs of the bridge that is not chosen stay low.

The command is asynchronous, so it first passes through a two-flop synchronizer. The block has two modes. In immediate mode the routing follows the synchronized command on the next clock. In timed mode a change of polarity blanks all four gates for a dead time of `DEAD_CYC` clock cycles, with a busy flag raised. The new bridge starts firing only when that interval ends. Both bridges therefore stay dark through every reversal. If the command moves again during the blanking interval, the interval starts over.

Top module: `bridge_polarity_steer`

## Requirements
- R1: While rst_ni is low, busy_o and both neg_gate_o bits are 0, and the selected polarity is positive.
- R2: With the synchronized command at 0, outside a dead time, pos_gate_o follows the gate inputs and neg_gate_o is 0.
- R3: With the synchronized command at 1, outside a dead time, neg_gate_o follows the gate inputs and pos_gate_o is 0.
- R4: In each output pair, bit 0 carries gate_a_i and bit 1 carries gate_b_i.
- R5: In immediate mode, a change of polarity_i made between clock edges first shows at the outputs after the third rising edge that follows it.
- R6: In timed mode, a change of the synchronized command to a polarity that differs from the selected one raises busy_o at that same (third) edge. busy_o then stays high for exactly DEAD_CYC cycles. All four gate outputs are 0 while busy_o is high, and the selected polarity does not change while the block is in timed mode and not busy.
- R7: A change of the synchronized command while busy_o is high reloads the full dead time. After that the command value then present is selected, which may be the old polarity.
- R8: The two output pairs are never both non-zero in the same cycle.
- R9: In immediate mode busy_o is 0. Switching timed_mode_i to 0 during a dead time clears busy_o at the next edge and selects the synchronized command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| polarity_i | input | 1 | Polarity command, asynchronous; 0 positive, 1 negative |
| timed_mode_i | input | 1 | 1 selects timed reversal with dead time, 0 immediate |
| gate_a_i | input | 1 | First gate train |
| gate_b_i | input | 1 | Second gate train, 180 degrees from the first |
| pos_gate_o | output | 2 | Positive-bridge gates {b, a} |
| neg_gate_o | output | 2 | Negative-bridge gates {b, a} |
| busy_o | output | 1 | Dead time in progress |

## Verification
The assertions assume that DEAD_CYC is at least 1. They also assume that timed_mode_i changes only between clock edges, like every other control input, so that each edge sees one settled mode. The minimum-length property is built on that assumption: it checks only those dead-time intervals whose closing edge saw timed mode. The bench drives polarity_i and timed_mode_i just after a rising edge, and it drives the gate trains from a shift-register pattern. The stimulus includes reversals in both directions, a reversal that reverts in the middle of a dead time, and a mode change that cuts a dead time short.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic {
    POL_POS = 1'b0,
    POL_NEG = 1'b1
  } pol_e;

  localparam int unsigned N_GATE = 2;
endpackage

// File: rtl/bps_sync.sv
module bps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/bps_dead_ctrl.sv
module bps_dead_ctrl
  import bps_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  pol_e cmd_i,
  input  logic timed_i,
  output pol_e act_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(DEAD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  pol_e             act_q, cmd_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= POL_POS;
      cmd_q <= POL_POS;
      cnt_q <= '0;
    end else begin
      cmd_q <= cmd_i;
      if (!timed_i) begin
        act_q <= cmd_i;
        cnt_q <= '0;
      end else if (cnt_q != '0) begin
        if (cmd_i != cmd_q) begin
          cnt_q <= CNT_LOAD;          // restart on a fresh change
        end else begin
          cnt_q <= cnt_q - CNT_ONE;
          if (cnt_q == CNT_ONE) act_q <= cmd_i;
        end
      end else if (cmd_i != act_q) begin
        cnt_q <= CNT_LOAD;
      end
    end
  end

  assign act_o  = act_q;
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/bps_gate_route.sv
module bps_gate_route
  import bps_pkg::*;
#(
  parameter int unsigned NG = N_GATE
) (
  input  logic [NG-1:0] gate_i,
  input  pol_e          act_i,
  input  logic          blank_i,
  output logic [NG-1:0] pos_o,
  output logic [NG-1:0] neg_o
);
  logic en_pos, en_neg;

  assign en_pos = !blank_i && (act_i == POL_POS);
  assign en_neg = !blank_i && (act_i == POL_NEG);

  for (genvar g = 0; g < NG; g++) begin : g_lane
    assign pos_o[g] = gate_i[g] & en_pos;
    assign neg_o[g] = gate_i[g] & en_neg;
  end
endmodule

// File: rtl/bridge_polarity_steer.sv
module bridge_polarity_steer
  import bps_pkg::*;
#(
  parameter int unsigned DEAD_CYC    = 5_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       polarity_i,
  input  logic       timed_mode_i,
  input  logic       gate_a_i,
  input  logic       gate_b_i,
  output logic [1:0] pos_gate_o,
  output logic [1:0] neg_gate_o,
  output logic       busy_o
);
  logic cmd_sync;
  pol_e act_pol;
  logic busy;

  bps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (polarity_i),
    .q_o   (cmd_sync)
  );

  bps_dead_ctrl #(.DEAD_CYC(DEAD_CYC)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (pol_e'(cmd_sync)),
    .timed_i(timed_mode_i),
    .act_o  (act_pol),
    .busy_o (busy)
  );

  bps_gate_route #(.NG(N_GATE)) u_route (
    .gate_i ({gate_b_i, gate_a_i}),
    .act_i  (act_pol),
    .blank_i(busy),
    .pos_o  (pos_gate_o),
    .neg_o  (neg_gate_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/bps_chk.sv
module bps_chk #(
  parameter int unsigned DEAD_CYC = 5_000_000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       timed_mode_i,
  input logic [1:0] pos_gate_o,
  input logic [1:0] neg_gate_o,
  input logic       busy_o,
  input logic       act_pol_i
);
  localparam int unsigned RUN_W = $clog2(DEAD_CYC + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         run_q <= '0;
    else if (!busy_o)                    run_q <= '0;
    else if (run_q != RUN_MAX)           run_q <= run_q + 1'b1;
  end

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_state_chk: assert (!busy_o && neg_gate_o == 2'b00);
    end
  end

  // R8
  excl_bridge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|pos_gate_o) && (|neg_gate_o)));

  // R6
  blank_gates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (pos_gate_o == 2'b00 && neg_gate_o == 2'b00));

  // R6
  hold_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timed_mode_i && !busy_o) |=> (act_pol_i == $past(act_pol_i)));

  // R6
  dead_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(busy_o) && $past(timed_mode_i)) |->
      (run_q >= RUN_W'(DEAD_CYC)));

  // R9
  imm_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !timed_mode_i |=> !busy_o);
endmodule

bind bridge_polarity_steer bps_chk #(.DEAD_CYC(DEAD_CYC)) u_bps_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .timed_mode_i(timed_mode_i),
  .pos_gate_o  (pos_gate_o),
  .neg_gate_o  (neg_gate_o),
  .busy_o      (busy_o),
  .act_pol_i   (act_pol)
);

// File: tb/bridge_polarity_steer_bench.sv
module bridge_polarity_steer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol_r = 1'b0;
  logic timed_r = 1'b0;
  logic ga = 1'b0, gb = 1'b0;
  logic [1:0] pos_o, neg_o;
  logic busy_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  bit hold_g = 0;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_polarity_steer #(.DEAD_CYC(DEAD)) u_bridge_polarity_steer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .polarity_i  (pol_r),
    .timed_mode_i(timed_r),
    .gate_a_i    (ga),
    .gate_b_i    (gb),
    .pos_gate_o  (pos_o),
    .neg_gate_o  (neg_o),
    .busy_o      (busy_o)
  );

  // behavioural reference
  int pipe[$];
  int m_act, m_cnt, m_prev, m_cmd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe = {0, 0};
      m_act = 0; m_cnt = 0; m_prev = 0;
    end else begin
      m_cmd = pipe[0];
      if (!timed_r) begin
        m_act = m_cmd; m_cnt = 0;
      end else if (m_cnt > 0) begin
        if (m_cmd != m_prev) m_cnt = DEAD;
        else begin
          if (m_cnt == 1) m_act = m_cmd;
          m_cnt = m_cnt - 1;
        end
      end else if (m_cmd != m_act) begin
        m_cnt = DEAD;
      end
      m_prev = m_cmd;
      void'(pipe.pop_front());
      pipe.push_back(int'(pol_r));
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [1:0] e_pos, e_neg;
      string tag;
      e_pos = (m_cnt == 0 && m_act == 0) ? {gb, ga} : 2'b00;
      e_neg = (m_cnt == 0 && m_act == 1) ? {gb, ga} : 2'b00;
      tag = (m_cnt != 0) ? "R6" : (m_act == 1) ? "R3" : "R2";
      chk(pos_o == e_pos, {tag, " pos"}, pos_o, e_pos);
      chk(neg_o == e_neg, {tag, " neg"}, neg_o, e_neg);
      chk(busy_o == (m_cnt != 0), "R6/R9 busy", busy_o, m_cnt != 0);
      chk(!((|pos_o) && (|neg_o)), "R8 exclusive", {pos_o, neg_o}, 0);
    end
  end

  task automatic adv();
    @(posedge clk);
    #1;
    if (!hold_g) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ga = lfsr[0];
      gb = lfsr[3];
    end
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt, lat;
    ga = 1'b1; gb = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(neg_o == 2'b00, "R1 neg", neg_o, 0);
    chk(pos_o == 2'b11, "R1 pos", pos_o, 3);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (10) adv();

    // R4 lane mapping on the positive pair
    hold_g = 1; ga = 1'b1; gb = 1'b0; adv();
    chk(pos_o == 2'b01, "R4 pos lane a", pos_o, 1);
    ga = 1'b0; gb = 1'b1; adv();
    chk(pos_o == 2'b10, "R4 pos lane b", pos_o, 2);

    // R5 latency in immediate mode
    ga = 1'b1; gb = 1'b1;
    pol_r = 1'b1;
    lat = 0;
    for (int k = 1; k <= 6; k++) begin
      adv();
      if (lat == 0 && neg_o != 2'b00) lat = k;
    end
    chk(lat == 3, "R5 latency", lat, 3);
    chk(busy_o == 1'b0, "R9 immediate idle", busy_o, 0);
    ga = 1'b0; gb = 1'b1; adv();
    chk(neg_o == 2'b10 && pos_o == 2'b00, "R3/R4 neg lane b", neg_o, 2);
    ga = 1'b1; gb = 1'b0; adv();
    chk(neg_o == 2'b01, "R4 neg lane a", neg_o, 1);
    hold_g = 0;
    repeat (8) adv();

    // R6 timed reversal back to positive
    timed_r = 1'b1;
    repeat (4) adv();
    pol_r = 1'b0;
    cnt = 0; lat = 0;
    for (int k = 1; k <= DEAD + 10; k++) begin
      adv();
      if (busy_o) cnt++;
      if (lat == 0 && busy_o) lat = k;
    end
    chk(lat == 3, "R6 busy start", lat, 3);
    chk(cnt == DEAD, "R6 dead length", cnt, DEAD);
    hold_g = 1; ga = 1'b1; gb = 1'b1; adv();
    chk(pos_o == 2'b11, "R6 new polarity", pos_o, 3);
    hold_g = 0;

    // R7 restart by a reverting command
    pol_r = 1'b1;
    cnt = 0;
    for (int k = 1; k <= 7; k++) begin adv(); if (busy_o) cnt++; end
    pol_r = 1'b0;
    for (int k = 1; k <= DEAD + 20; k++) begin adv(); if (busy_o) cnt++; end
    chk(cnt == DEAD + 7, "R7 restarted length", cnt, DEAD + 7);
    hold_g = 1; ga = 1'b1; gb = 1'b0; adv();
    chk(pos_o == 2'b01 && neg_o == 2'b00, "R7 old polarity kept", pos_o, 1);
    hold_g = 0;

    // R9 mode change cuts a dead time short
    pol_r = 1'b1;
    repeat (6) adv();
    chk(busy_o == 1'b1, "R9 busy before cut", busy_o, 1);
    timed_r = 1'b0;
    adv();
    chk(busy_o == 1'b0, "R9 cleared", busy_o, 0);
    hold_g = 1; ga = 1'b1; gb = 1'b1; adv();
    chk(neg_o == 2'b11, "R9 selects command", neg_o, 3);
    hold_g = 0;

    // mixed traffic
    for (int r = 0; r < 40; r++) begin
      if (r % 7 == 3) pol_r = ~pol_r;
      if (r % 13 == 5) timed_r = ~timed_r;
      adv();
    end
    timed_r = 1'b1;
    for (int r = 0; r < 120; r++) begin
      if (r % 9 == 0) pol_r = ~pol_r;
      adv();
    end
    repeat (DEAD + 6) adv();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule